// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block listens to a CPU write bus and assembles four 5-bit configuration registers one bit at a time. Each write into the upper half of a 16-bit address space carries a single payload bit in data bit 0. Five such writes fill a shift buffer, least significant bit first. The fifth write copies the buffer into one of the four registers, chosen by the address of that write. Software can abort a partial load at any time with a write that has data bit 7 set. The abort also switches register 0 into a mode with a fixed last program bank by setting two of its bits.

Some processors issue two back-to-back writes to the same address during a read-modify-write instruction. To handle this, the block ignores every write that arrives in the cycle after an accepted abort. The downstream bank logic reads the registers directly. A one-cycle commit strobe with the register index marks every load.

Top module: `serial_cfg_loader`

## Requirements
- R1: After synchronous reset, register 0 reads 0x1F, registers 1 to 3 read 0, the shift buffer is empty and `commit_valid` is low.
- R2: A write whose address bit 15 is 0 changes no register, raises no commit strobe, and leaves the partial contents of the shift buffer intact.
- R3: An accepted write with data bit 7 clear shifts data bit 0 into the buffer. The first such write fills bit 0 and the fifth fills bit 4.
- R4: The destination register is given by address bits 14:13 of the fifth write only (0x8000 selects 0, 0xA000 selects 1, 0xC000 selects 2, 0xE000 selects 3). The addresses of the first four writes do not matter, as long as bit 15 is 1.
- R5: An accepted in-range write with data bit 7 set empties the buffer and sets bits 3:2 of register 0. Bits 4, 1 and 0 of register 0 and the other three registers keep their values. No register is loaded.
- R6: A write in the cycle right after an accepted abort is ignored, whether it is a data bit or another abort. A write two cycles after the abort is accepted.
- R7: Each register load raises `commit_valid` for exactly one cycle, with `commit_idx` naming the register. The new value is visible on `cfg_regs` in that same cycle.
- R8: After a load, the buffer starts empty, so the next five accepted writes form a wholly new value.
- R9: Data bits 6:1 have no effect on any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | Write address |
| cpu_data | input | 8 | Write data |
| cfg_regs | output | 20 | Registers 0..3 packed, register n in bits 5n+4:5n |
| commit_valid | output | 1 | One-cycle pulse on every register load |
| commit_idx | output | 2 | Index of the register just loaded |

## Verification
The bench varies the addresses of the first four writes of a load. A design that latched the index early would send the value to the wrong register. It also puts out-of-range writes in the middle of a partial load, which exposes a loader that counts them or clears the buffer on them. An ignored data write is placed directly after an abort, followed by a full load. A missing or over-long guard window shows up as a shifted value or a lost bit. A design that wiped register 0 on an abort, instead of OR-ing in the mode bits, fails the check of register 0 that follows.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Classification of one bus cycle after address and guard checks.
  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_BIT   = 2'd1,
    WK_ABORT = 2'd2
  } wr_kind_e;

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              allowed,
  output wr_kind_e          kind,
  output logic [IDX_W-1:0]  idx,
  output logic              bit_in
);

  logic in_window;

  assign in_window = addr[ADDR_W-1];
  assign idx       = addr[ADDR_W-2 -: IDX_W];
  assign bit_in    = data[0];

  always_comb begin
    kind = WK_NONE;
    if (wr && in_window && allowed)
      kind = data[DATA_W-1] ? WK_ABORT : WK_BIT;
  end

endmodule

// File: rtl/cfg_guard_timer.sv
module cfg_guard_timer #(
  parameter int GUARD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic abort_hit,
  output logic open
);

  localparam int CNT_W = $clog2(GUARD_CYCLES + 1);

  logic [CNT_W-1:0] since_abort;

  assign open = (since_abort >= CNT_W'(GUARD_CYCLES));

  // Saturates at GUARD_CYCLES, so it never wraps back into the window.
  always_ff @(posedge clk) begin
    if (rst)
      since_abort <= CNT_W'(GUARD_CYCLES);
    else if (abort_hit)
      since_abort <= CNT_W'(1);
    else if (!open)
      since_abort <= since_abort + CNT_W'(1);
  end

endmodule

// File: rtl/cfg_shift_buffer.sv
module cfg_shift_buffer
  import cfg_loader_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_kind_e         kind,
  input  logic             bit_in,
  output logic             done,
  output logic [REG_W-1:0] value
);

  localparam int CNT_W = $clog2(REG_W);

  logic [REG_W-1:0] acc;
  logic [CNT_W-1:0] fill;

  assign done  = (kind == WK_BIT) && (fill == CNT_W'(REG_W - 1));
  assign value = acc | (REG_W'(bit_in) << fill);

  always_ff @(posedge clk) begin
    if (rst || kind == WK_ABORT || done) begin
      acc  <= '0;
      fill <= '0;
    end else if (kind == WK_BIT) begin
      acc  <= value;
      fill <= fill + CNT_W'(1);
    end
  end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_loader_pkg::*;
#(
  parameter int               NUM_REGS  = 4,
  parameter int               REG_W     = 5,
  parameter logic [REG_W-1:0] RESET0    = 5'h1F,
  parameter logic [REG_W-1:0] ABORT_SET = 5'h0C
) (
  input  logic                      clk,
  input  logic                      rst,
  input  wr_kind_e                  kind,
  input  logic                      load,
  input  logic [$clog2(NUM_REGS)-1:0] load_idx,
  input  logic [REG_W-1:0]          load_val,
  output logic [NUM_REGS*REG_W-1:0] regs
);

  localparam int IDX_W = $clog2(NUM_REGS);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= (i == 0) ? RESET0 : '0;
      else if (load && load_idx == IDX_W'(i))
        q <= load_val;
      else if (i == 0 && kind == WK_ABORT)
        q <= q | ABORT_SET;
    end
    assign regs[i*REG_W +: REG_W] = q;
  end

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int               ADDR_W       = 16,
  parameter int               DATA_W       = 8,
  parameter int               NUM_REGS     = 4,
  parameter int               REG_W        = 5,
  parameter int               GUARD_CYCLES = 2,
  parameter logic [REG_W-1:0] RESET0       = 5'h1F,
  parameter logic [REG_W-1:0] ABORT_SET    = 5'h0C
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cpu_wr,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_data,
  output logic [NUM_REGS*REG_W-1:0]     cfg_regs,
  output logic                          commit_valid,
  output logic [$clog2(NUM_REGS)-1:0]   commit_idx
);

  localparam int IDX_W = $clog2(NUM_REGS);

  wr_kind_e         kind;
  logic [IDX_W-1:0] idx;
  logic             bit_in;
  logic             wr_open;
  logic             done;
  logic [REG_W-1:0] value;

  cfg_addr_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_dec (
    .wr      (cpu_wr),
    .addr    (cpu_addr),
    .data    (cpu_data),
    .allowed (wr_open),
    .kind    (kind),
    .idx     (idx),
    .bit_in  (bit_in)
  );

  cfg_guard_timer #(
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_guard (
    .clk       (clk),
    .rst       (rst),
    .abort_hit (kind == WK_ABORT),
    .open      (wr_open)
  );

  cfg_shift_buffer #(
    .REG_W (REG_W)
  ) u_shift (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .bit_in (bit_in),
    .done   (done),
    .value  (value)
  );

  cfg_reg_bank #(
    .NUM_REGS  (NUM_REGS),
    .REG_W     (REG_W),
    .RESET0    (RESET0),
    .ABORT_SET (ABORT_SET)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .load     (done),
    .load_idx (idx),
    .load_val (value),
    .regs     (cfg_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_valid <= 1'b0;
      commit_idx   <= '0;
    end else begin
      commit_valid <= done;
      commit_idx   <= done ? idx : commit_idx;
    end
  end

endmodule

// File: rtl/serial_cfg_loader_checks.sv
module serial_cfg_loader_checks #(
  parameter int               ADDR_W    = 16,
  parameter int               DATA_W    = 8,
  parameter int               NUM_REGS  = 4,
  parameter int               REG_W     = 5,
  parameter logic [REG_W-1:0] ABORT_SET = 5'h0C
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cpu_wr,
  input logic [ADDR_W-1:0]             cpu_addr,
  input logic [DATA_W-1:0]             cpu_data,
  input logic                          wr_open,
  input logic [NUM_REGS*REG_W-1:0]     cfg_regs,
  input logic                          commit_valid,
  input logic [$clog2(NUM_REGS)-1:0]   commit_idx
);

  logic abort_acc;
  assign abort_acc = cpu_wr && cpu_addr[ADDR_W-1] && cpu_data[DATA_W-1] && wr_open;

  a_r2_outside_ignored: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && !cpu_addr[ADDR_W-1]) |=> ($stable(cfg_regs) && !commit_valid));

  a_r5_abort_sets_mode: assert property (@(posedge clk) disable iff (rst)
    abort_acc |=> (((cfg_regs[REG_W-1:0] & ABORT_SET) == ABORT_SET)
                   && $stable(cfg_regs[REG_W-1:0] & ~ABORT_SET)
                   && $stable(cfg_regs[NUM_REGS*REG_W-1:REG_W])
                   && !commit_valid));

  a_r6_guard_closes: assert property (@(posedge clk) disable iff (rst)
    abort_acc |=> !wr_open);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    commit_valid |=> !commit_valid);

  a_r7_commit_from_write: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> $past(cpu_wr && cpu_addr[ADDR_W-1] && !cpu_data[DATA_W-1] && wr_open));

  a_r7_idx_matches_addr: assert property (@(posedge clk) disable iff (rst)
    commit_valid |-> (commit_idx == $past(cpu_addr[ADDR_W-2 -: $clog2(NUM_REGS)])));

endmodule

bind serial_cfg_loader serial_cfg_loader_checks #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_REGS  (NUM_REGS),
  .REG_W     (REG_W),
  .ABORT_SET (ABORT_SET)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cpu_wr       (cpu_wr),
  .cpu_addr     (cpu_addr),
  .cpu_data     (cpu_data),
  .wr_open      (wr_open),
  .cfg_regs     (cfg_regs),
  .commit_valid (commit_valid),
  .commit_idx   (commit_idx)
);

// File: tb/serial_cfg_loader_test.sv
`timescale 1ns/1ps
module serial_cfg_loader_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [19:0] cfg_regs;
  logic        commit_valid;
  logic [1:0]  commit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [4:0] exp_reg [4];
  logic [6:0] sb_q [$];

  always #10 clk = ~clk;

  serial_cfg_loader uut (
    .clk          (clk),
    .rst          (rst),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_data     (cpu_data),
    .cfg_regs     (cfg_regs),
    .commit_valid (commit_valid),
    .commit_idx   (commit_idx)
  );

  function automatic logic [4:0] reg_of(int n);
    return cfg_regs[n*5 +: 5];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    for (int n = 0; n < 4; n++) check(req, 32'(reg_of(n)), 32'(exp_reg[n]));
  endtask

  // Drive one write for one cycle; consecutive calls are back-to-back.
  task automatic put(logic [15:0] a, logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Five writes; only the fifth carries the real index (R4).
  task automatic load(int idx, logic [4:0] v, logic [7:0] noise);
    for (int i = 0; i < 5; i++) begin
      logic [15:0] a;
      if (i == 4) begin
        a = 16'h8000 | 16'(idx << 13);
        sb_q.push_back({2'(idx), v});
        exp_reg[idx] = v;
      end else begin
        a = 16'h8000 | 16'(((idx + i + 1) % 4) << 13) | 16'(i * 7);
      end
      put(a, (noise & 8'h7E) | {7'd0, v[i]});
    end
  endtask

  task automatic do_abort(logic [15:0] a, logic [7:0] d);
    put(a, d | 8'h80);
    exp_reg[0] = exp_reg[0] | 5'h0C;
  endtask

  // Scoreboard monitor (R7)
  always @(negedge clk) begin
    if (!rst && commit_valid) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: actual unexpected commit idx %0d expected none", commit_idx);
      end else begin
        logic [6:0] e;
        e = sb_q.pop_front();
        check("R7 idx", 32'(commit_idx), 32'(e[6:5]));
        check("R3 value", 32'(reg_of(int'(e[6:5]))), 32'(e[4:0]));
      end
    end
  end

  initial begin
    exp_reg[0] = 5'h1F; exp_reg[1] = 0; exp_reg[2] = 0; exp_reg[3] = 0;
    idle(3);
    rst = 1'b0;
    idle(1);
    check_regs("R1");
    check("R1 strobe", 32'(commit_valid), 0);

    // R3/R4/R8: consecutive loads with scattered early addresses
    load(1, 5'h15, 8'h00);
    load(2, 5'h0A, 8'h00);
    load(3, 5'h1E, 8'h00);
    load(0, 5'h03, 8'h00);
    idle(1);
    check_regs("R8");

    // R9: noise on bits 6:1
    load(2, 5'h11, 8'h7E);
    idle(1);
    check_regs("R9");

    // R2: out-of-range writes alone, then mixed into a partial load
    for (int i = 0; i < 5; i++) put(16'h6000 | 16'(i), 8'h01);
    idle(1);
    check_regs("R2");
    put(16'hA000, 8'h01);
    put(16'hA000, 8'h00);
    for (int i = 0; i < 3; i++) put(16'h7FFF, 8'h01);
    put(16'hA000, 8'h01);
    put(16'hA000, 8'h00);
    sb_q.push_back({2'd1, 5'h05}); exp_reg[1] = 5'h05;
    put(16'hA000, 8'h00);
    idle(1);
    check_regs("R2 partial");

    // R5: abort mid-load keeps other regs and low bits of reg0
    put(16'hC000, 8'h01);
    put(16'hC000, 8'h01);
    do_abort(16'hC000, 8'h01);
    idle(1);
    check_regs("R5");
    load(2, 5'h02, 8'h00);
    idle(1);
    check_regs("R5 buffer");

    // R6: write right after abort ignored, two cycles later accepted
    load(0, 5'h10, 8'h00);
    do_abort(16'hE000, 8'h00);
    put(16'hE000, 8'h01);
    load(3, 5'h04, 8'h00);
    idle(1);
    check_regs("R6");
    do_abort(16'h8000, 8'h00);
    do_abort(16'h8000, 8'h00);
    load(1, 5'h19, 8'h00);
    idle(1);
    check_regs("R6 double");

    idle(2);
    check("R7 drained", 32'(sb_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule